// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a multi-cycle 32-bit processor datapath for a small load/store instruction subset. It walks each instruction through a fetch step, a decode and operand-read step, and then, depending on the opcode, an execute, memory and write-back step. Because the datapath reuses its single ALU and single memory across steps, every control output depends on the current step and not only on the instruction bits. Loads take five cycles, stores and register-register operations four, and branches and jumps three.

The datapath feeds the block the 6-bit opcode field of its instruction register and the ALU zero flag. In return the block drives every datapath enable and multiplexer select. During fetch the ALU computes PC+4. During decode it speculatively computes the branch target into the ALU output register before the opcode is known. The branch compare then only has to subtract and conditionally load the PC.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, the outputs show the fetch step: pc_wr=1, pc_load=1, ir_wr=1, mem_rd=1, mem_addr_alu=0, alu_a_reg=0, alu_b_sel=01 (constant 4), alu_cls=00, pc_src=00 (ALU result), and every other output is 0. Reset is asynchronous and may arrive in any step.
- R2: The step after every fetch is decode: alu_a_reg=0, alu_b_sel=11 (shifted sign-extended offset), alu_cls=00, and no write enable or memory strobe is active.
- R3: A load (opcode 35) takes 5 cycles. Step 3 has alu_a_reg=1, alu_b_sel=10 (sign-extended offset) and alu_cls=00. Step 4 has mem_rd=1 and mem_addr_alu=1. Step 5 has rf_wr=1, rf_from_mem=1 and rf_dst_rd=0. Fetch follows.
- R4: A store (opcode 43) takes 4 cycles. Its step 3 is the same as for a load. Step 4 has mem_wr=1 and mem_addr_alu=1 with no register write. Fetch follows.
- R5: A register-register operation (opcode 0) takes 4 cycles. Step 3 has alu_a_reg=1, alu_b_sel=00 (register B) and alu_cls=10. Step 4 has rf_wr=1, rf_dst_rd=1 and rf_from_mem=0. Fetch follows.
- R6: A branch-if-equal (opcode 4) takes 3 cycles. Step 3 has pc_wr_cond=1, pc_wr=0, pc_src=01 (ALU output register), alu_a_reg=1, alu_b_sel=00 and alu_cls=01.
- R7: A jump (opcode 2) takes 3 cycles. Step 3 has pc_wr=1 and pc_src=10 (jump target), and no other write enable or memory strobe is active.
- R8: Any other opcode returns from decode directly to fetch, so no write enable, memory strobe or conditional PC write is raised for it.
- R9: pc_load equals pc_wr OR (pc_wr_cond AND alu_zero) in every cycle. alu_zero therefore has no effect on any output outside the branch compare step.
- R10: mem_rd and mem_wr are never high in the same cycle.
- R11: The opcode is ignored during fetch: the decode step follows fetch whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU zero flag |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by alu_zero |
| pc_load | output | 1 | Effective PC write enable |
| ir_wr | output | 1 | Instruction register write |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr_alu | output | 1 | Memory address from ALU output register (1) or PC (0) |
| rf_wr | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Destination from bits 15:11 (1) or 20:16 (0) |
| rf_from_mem | output | 1 | Write data from memory data register (1) or ALU output register (0) |
| alu_a_reg | output | 1 | ALU operand A from register A (1) or PC (0) |
| alu_b_sel | output | 2 | ALU operand B: 00 register B, 01 constant 4, 10 offset, 11 offset shifted by 2 |
| alu_cls | output | 2 | ALU operation class: 00 add, 01 subtract, 10 by function field |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |

## Verification
The hardest state to reach from the ports is an asynchronous reset arriving deep inside a long instruction, such as the memory-read step of a load, together with a stale or garbage opcode on the input during fetch. The bench first runs a table of instructions back to back, checking every output in every step and holding the zero flag both high and low. It then drives a load part way, pulls reset in the middle of its memory step, and confirms that the fetch outputs appear at once. Finally it presents a foreign opcode during a fetch and swaps in the real one only at decode.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int OP_W   = 6;
  localparam int STEP_W = 3;
  localparam int MAX_STEPS = 5;

  localparam logic [OP_W-1:0] OPC_ALU    = 6'd0;
  localparam logic [OP_W-1:0] OPC_JUMP   = 6'd2;
  localparam logic [OP_W-1:0] OPC_BRANCH = 6'd4;
  localparam logic [OP_W-1:0] OPC_LOAD   = 6'd35;
  localparam logic [OP_W-1:0] OPC_STORE  = 6'd43;

  localparam logic [1:0] ALUB_REG   = 2'b00;
  localparam logic [1:0] ALUB_FOUR  = 2'b01;
  localparam logic [1:0] ALUB_IMM   = 2'b10;
  localparam logic [1:0] ALUB_IMMSH = 2'b11;

  localparam logic [1:0] CLS_ADD  = 2'b00;
  localparam logic [1:0] CLS_SUB  = 2'b01;
  localparam logic [1:0] CLS_FUNC = 2'b10;

  localparam logic [1:0] PCS_ALU = 2'b00;
  localparam logic [1:0] PCS_OUT = 2'b01;
  localparam logic [1:0] PCS_JMP = 2'b10;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_LDMEM, ST_LDWB,
    ST_STMEM, ST_ALUEX, ST_ALUWB, ST_BRCMP, ST_JUMP
  } step_e;

  typedef enum logic [2:0] {
    K_LOAD, K_STORE, K_ALU, K_BRANCH, K_JUMP, K_NONE
  } kind_e;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       ir_wr;
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_alu;
    logic       rf_wr;
    logic       rf_dst_rd;
    logic       rf_from_mem;
    logic       alu_a_reg;
    logic [1:0] alu_b;
    logic [1:0] alu_cls;
    logic [1:0] pc_src;
  } ctrl_t;

  function automatic kind_e classify(input logic [OP_W-1:0] op);
    case (op)
      OPC_LOAD:   return K_LOAD;
      OPC_STORE:  return K_STORE;
      OPC_ALU:    return K_ALU;
      OPC_BRANCH: return K_BRANCH;
      OPC_JUMP:   return K_JUMP;
      default:    return K_NONE;
    endcase
  endfunction

  function automatic logic pc_enable(input logic wr, input logic wr_cond,
                                     input logic zero);
    return wr | (wr_cond & zero);
  endfunction
endpackage

// File: rtl/mcc_decode.sv
module mcc_decode
  import mcc_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output kind_e           kind
);
  assign kind = classify(opcode);
endmodule

// File: rtl/mcc_sequencer.sv
module mcc_sequencer
  import mcc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  kind_e kind,
  output step_e state
);
  step_e nxt;
  logic [STEP_W-1:0] step_cnt;
  logic              ends_instr;

  always_comb begin
    nxt = ST_FETCH;
    case (state)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        case (kind)
          K_LOAD, K_STORE: nxt = ST_ADDR;
          K_ALU:           nxt = ST_ALUEX;
          K_BRANCH:        nxt = ST_BRCMP;
          K_JUMP:          nxt = ST_JUMP;
          default:         nxt = ST_FETCH;
        endcase
      end
      ST_ADDR:   nxt = (kind == K_LOAD) ? ST_LDMEM : ST_STMEM;
      ST_LDMEM:  nxt = ST_LDWB;
      ST_ALUEX:  nxt = ST_ALUWB;
      default:   nxt = ST_FETCH;
    endcase
  end

  assign ends_instr = (nxt == ST_FETCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_FETCH;
      step_cnt <= '0;
    end else begin
      state    <= nxt;
      step_cnt <= ends_instr ? '0 : step_cnt + 1'b1;
    end
  end

  // R11
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FETCH |=> state == ST_DECODE);

  // R8
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE && kind == K_NONE) |=> state == ST_FETCH);

  // R3
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_cnt < STEP_W'(MAX_STEPS));
endmodule

// File: rtl/mcc_outmap.sv
module mcc_outmap
  import mcc_pkg::*;
(
  input  step_e state,
  output ctrl_t ctl
);
  always_comb begin
    ctl = '0;
    case (state)
      ST_FETCH: begin
        ctl.mem_rd = 1'b1;
        ctl.ir_wr  = 1'b1;
        ctl.alu_b  = ALUB_FOUR;
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = PCS_ALU;
      end
      ST_DECODE: ctl.alu_b = ALUB_IMMSH;
      ST_ADDR: begin
        ctl.alu_a_reg = 1'b1;
        ctl.alu_b     = ALUB_IMM;
      end
      ST_LDMEM: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_alu = 1'b1;
      end
      ST_LDWB: begin
        ctl.rf_wr       = 1'b1;
        ctl.rf_from_mem = 1'b1;
      end
      ST_STMEM: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_alu = 1'b1;
      end
      ST_ALUEX: begin
        ctl.alu_a_reg = 1'b1;
        ctl.alu_b     = ALUB_REG;
        ctl.alu_cls   = CLS_FUNC;
      end
      ST_ALUWB: begin
        ctl.rf_wr     = 1'b1;
        ctl.rf_dst_rd = 1'b1;
      end
      ST_BRCMP: begin
        ctl.alu_a_reg  = 1'b1;
        ctl.alu_b      = ALUB_REG;
        ctl.alu_cls    = CLS_SUB;
        ctl.pc_wr_cond = 1'b1;
        ctl.pc_src     = PCS_OUT;
      end
      ST_JUMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = PCS_JMP;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  input  logic            alu_zero,
  output logic            pc_wr,
  output logic            pc_wr_cond,
  output logic            pc_load,
  output logic            ir_wr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            mem_addr_alu,
  output logic            rf_wr,
  output logic            rf_dst_rd,
  output logic            rf_from_mem,
  output logic            alu_a_reg,
  output logic [1:0]      alu_b_sel,
  output logic [1:0]      alu_cls,
  output logic [1:0]      pc_src
);
  kind_e kind;
  step_e state;
  ctrl_t ctl;

  mcc_decode u_dec (.opcode(opcode), .kind(kind));
  mcc_sequencer u_seq (.clk(clk), .rst_n(rst_n), .kind(kind), .state(state));
  mcc_outmap u_map (.state(state), .ctl(ctl));

  assign pc_wr        = ctl.pc_wr;
  assign pc_wr_cond   = ctl.pc_wr_cond;
  assign ir_wr        = ctl.ir_wr;
  assign mem_rd       = ctl.mem_rd;
  assign mem_wr       = ctl.mem_wr;
  assign mem_addr_alu = ctl.addr_alu;
  assign rf_wr        = ctl.rf_wr;
  assign rf_dst_rd    = ctl.rf_dst_rd;
  assign rf_from_mem  = ctl.rf_from_mem;
  assign alu_a_reg    = ctl.alu_a_reg;
  assign alu_b_sel    = ctl.alu_b;
  assign alu_cls      = ctl.alu_cls;
  assign pc_src       = ctl.pc_src;
  assign pc_load      = pc_enable(ctl.pc_wr, ctl.pc_wr_cond, alu_zero);

  // R10
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R9
  pc_load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !pc_wr) |-> (pc_wr_cond && alu_zero));

  // R3
  wb_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |=> ir_wr);

  // R4
  st_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ir_wr);

  // R7
  jmp_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == PCS_JMP) |=> ir_wr);

  // R6
  br_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_cond |=> ir_wr);
endmodule

// File: tb/mc_ctrl_fsm_test.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic alu_zero = 1'b0;
  logic pc_wr, pc_wr_cond, pc_load, ir_wr, mem_rd, mem_wr, mem_addr_alu;
  logic rf_wr, rf_dst_rd, rf_from_mem, alu_a_reg;
  logic [1:0] alu_b_sel, alu_cls, pc_src;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  mc_ctrl_fsm uut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_load(pc_load), .ir_wr(ir_wr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr_alu(mem_addr_alu),
    .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd), .rf_from_mem(rf_from_mem),
    .alu_a_reg(alu_a_reg), .alu_b_sel(alu_b_sel), .alu_cls(alu_cls),
    .pc_src(pc_src)
  );

  // word layout: pc_wr pc_wr_cond pc_load ir_wr mem_rd mem_wr addr rf_wr
  //              rf_dst rf_mem alu_a alu_b[1:0] alu_cls[1:0] pc_src[1:0]
  function automatic logic [16:0] pack(logic pw, logic pc, logic pl, logic ir,
      logic rd, logic wr, logic ad, logic rw, logic rdst, logic rm, logic aa,
      logic [1:0] bb, logic [1:0] cl, logic [1:0] ps);
    return {pw, pc, pl, ir, rd, wr, ad, rw, rdst, rm, aa, bb, cl, ps};
  endfunction

  function automatic logic [16:0] fetch_word();
    return pack(1,0,1,1,1,0,0,0,0,0,0,2'b01,2'b00,2'b00);
  endfunction

  function automatic logic [16:0] expect_word(logic [5:0] op, logic z, int s);
    if (s == 0) return fetch_word();
    if (s == 1) return pack(0,0,0,0,0,0,0,0,0,0,0,2'b11,2'b00,2'b00);
    if (s == 2) begin
      if (op == 6'd35 || op == 6'd43) return pack(0,0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,2'b00);
      if (op == 6'd0)  return pack(0,0,0,0,0,0,0,0,0,0,1,2'b00,2'b10,2'b00);
      if (op == 6'd4)  return pack(0,1,z,0,0,0,0,0,0,0,1,2'b00,2'b01,2'b01);
      if (op == 6'd2)  return pack(1,0,1,0,0,0,0,0,0,0,0,2'b00,2'b00,2'b10);
      return fetch_word();
    end
    if (s == 3) begin
      if (op == 6'd35) return pack(0,0,0,0,1,0,1,0,0,0,0,2'b00,2'b00,2'b00);
      if (op == 6'd43) return pack(0,0,0,0,0,1,1,0,0,0,0,2'b00,2'b00,2'b00);
      return pack(0,0,0,0,0,0,0,1,1,0,0,2'b00,2'b00,2'b00);
    end
    return pack(0,0,0,0,0,0,0,1,0,1,0,2'b00,2'b00,2'b00);
  endfunction

  function automatic logic [16:0] observed();
    return {pc_wr, pc_wr_cond, pc_load, ir_wr, mem_rd, mem_wr, mem_addr_alu,
            rf_wr, rf_dst_rd, rf_from_mem, alu_a_reg, alu_b_sel, alu_cls, pc_src};
  endfunction

  task automatic check(string tag, logic [16:0] exp);
    total++;
    if (observed() !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, observed(), exp);
    end
  endtask

  // run one instruction starting mid-cycle in fetch; ends at the negedge of the next fetch
  task automatic run_instr(logic [5:0] op, logic z, int n, string tag);
    for (int s = 0; s < n; s++) begin
      opcode = op;
      alu_zero = z;
      #1;
      check($sformatf("%s step%0d", tag, s + 1), expect_word(op, z, s));
      @(negedge clk);
    end
  endtask

  // row: opcode, zero flag, cycle count
  localparam int NROWS = 11;
  localparam logic [9:0] VEC [NROWS] = '{
    {6'd35, 1'b0, 3'd5},
    {6'd43, 1'b1, 3'd4},
    {6'd0,  1'b0, 3'd4},
    {6'd0,  1'b1, 3'd4},
    {6'd4,  1'b1, 3'd3},
    {6'd4,  1'b0, 3'd3},
    {6'd2,  1'b0, 3'd3},
    {6'd63, 1'b1, 3'd2},
    {6'd5,  1'b0, 3'd2},
    {6'd35, 1'b1, 3'd5},
    {6'd2,  1'b1, 3'd3}
  };

  function automatic string row_tag(logic [5:0] op);
    case (op)
      6'd35: return "R3 load";
      6'd43: return "R4 store";
      6'd0:  return "R5 alu";
      6'd4:  return "R6 branch";
      6'd2:  return "R7 jump";
      default: return "R8 unknown";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 during reset", fetch_word());
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check("R1 first cycle after reset", fetch_word());

    for (int i = 0; i < NROWS; i++) begin
      run_instr(VEC[i][9:4], VEC[i][3], int'(VEC[i][2:0]), row_tag(VEC[i][9:4]));
      #1;
      check($sformatf("%s returns to fetch (R2/R8)", row_tag(VEC[i][9:4])), fetch_word());
    end

    // R9: zero flag has no effect in fetch
    alu_zero = 1'b0;
    #0.5;
    check("R9 zero low in fetch", fetch_word());

    // R1: reset in the middle of a load's memory step
    opcode = 6'd35;
    alu_zero = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R3 load step4 before reset", expect_word(6'd35, 1'b0, 3));
    rst_n = 1'b0;
    #0.5;
    check("R1 reset mid-instruction", fetch_word());
    @(negedge clk);
    rst_n = 1'b1;
    run_instr(6'd4, 1'b1, 3, "R1 after reset branch");

    // R11: opcode ignored during fetch
    opcode = 6'd43;
    #1;
    check("R11 fetch with foreign opcode", fetch_word());
    @(negedge clk);
    opcode = 6'd0;
    #1;
    check("R11 decode follows fetch", expect_word(6'd0, 1'b0, 1));
    @(negedge clk);
    #1;
    check("R11 alu execute", expect_word(6'd0, 1'b0, 2));
    @(negedge clk);
    #1;
    check("R11 alu writeback", expect_word(6'd0, 1'b0, 3));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule